// File: doc/BRIEF.md
# Byte-Wide Memory Mode and Command Decoder

This block is the control front end of an electrically erasable, byte-wide non-volatile memory. Each clock it samples the active-low chip select, output enable and write strobe, together with the address, the input byte and two digitised level flags. One flag says the programming supply is raised. The other says address bit 9 is at high voltage. From these it decides the operating mode. It drives the enable for the tri-state data bus, a select that picks what a read returns (array contents or one of two identifier bytes), the identifier byte itself, and a standby flag.

Writes are recognised when the write strobe returns high. A qualified write gives a one-cycle program strobe or a one-cycle erase strobe. Each strobe carries the captured address, the captured byte and the strobe's low time in clock cycles, so that an array model can apply the operation. The array model programs by clearing bits and erases to all ones. Chip erase can start in two ways. The first is a strobe while address bit 9 is at high voltage and address bit 0 is low. The second is a two-write unlock pair: 0xAA to address 0x5555, then 0x10 to address 0x2AAA.

Top module: `eprom_mode_ctl`

## Requirements
- R1: While chip select is high, the cycle after sampling gives standby=1, bus_oe=0 and mode=0 (standby), whatever the output enable and write strobe do. Reset also leaves standby=1, bus_oe=0, mode=0 and both strobes low.
- R2: With chip select low, output enable low and both level flags low, the next cycle shows mode=2 (read), bus_oe=1 and rd_sel=0 (array). With output enable high and the programming supply low, it shows mode=1 (output disabled) and bus_oe=0.
- R3: With the high-voltage flag set, the programming supply low, and chip select and output enable low, the mode is 3 (identifier read). rd_sel=1 with id_byte=0xDA when address bit 0 is 0. rd_sel=2 with id_byte=0x85 when address bit 0 is 1.
- R4: With the programming supply raised and chip select and output enable low, the mode is 4 (verify), with bus_oe=1 and rd_sel=0.
- R5: With the supply raised, chip select low and output enable high, a low write strobe gives mode=5 (program pulse). In the cycle after the strobe's rising edge is sampled, prog_stb=1 for exactly one cycle. op_addr and op_data then hold the inputs present at release, and pulse_cycles equals the number of clocks that sampled the strobe low.
- R6: A strobe release with chip select high, with output enable low, or with the programming supply low produces neither prog_stb nor erase_stb.
- R7: A qualified write with the high-voltage flag set and address bit 0 low gives mode=6 (erase pulse) while the strobe is low, then erase_stb, not prog_stb. With address bit 0 high, the same write is an ordinary program.
- R8: From idle, a write of 0xAA to address 0x5555 (full address compared) produces no strobe and arms the unlock detector.
- R9: While armed, a write of 0x10 to address 0x2AAA produces erase_stb carrying its own pulse_cycles, and disarms the detector.
- R10: While armed, any other write disarms the detector and is issued as prog_stb. A repeated 0xAA to 0x5555 keeps the detector armed with no strobe. A write of 0x10 to 0x2AAA while idle is an ordinary program.
- R11: prog_stb and erase_stb are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Write strobe, active low |
| vpp_hi | input | 1 | Programming supply is raised |
| a9_hv | input | 1 | Address bit 9 is at high voltage |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Input byte |
| bus_oe | output | 1 | Drive the data bus |
| rd_sel | output | 2 | Read source: 0 array, 1 maker code, 2 device code |
| id_byte | output | DATA_W | Identifier byte for the selected source, else 0 |
| mode | output | 3 | Decoded operating mode |
| standby | output | 1 | Chip deselected |
| prog_stb | output | 1 | One-cycle program request |
| erase_stb | output | 1 | One-cycle chip erase request |
| op_addr | output | ADDR_W | Address captured at strobe release |
| op_data | output | DATA_W | Byte captured at strobe release |
| pulse_cycles | output | PW_W | Strobe low time in clock cycles |

## Verification
Mode decoding is driven through every static combination that selects a distinct mode: deselected with noisy enables, plain read, output disabled, both identifier addresses, and verify. Write strobes of several lengths are released under each disqualifying condition, which separates qualification from edge detection. The high-voltage erase is tried with address bit 0 both low and high, to show that the bit steers erase against program. The unlock detector sees the proper pair, a pair broken by an unrelated write, a repeated first command, and a lone second command, which distinguishes arming, disarming and the fallback to programming.

// File: rtl/eprom_ctl_pkg.sv
package eprom_ctl_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_OUT_DIS = 3'd1,
        MD_READ    = 3'd2,
        MD_ID_READ = 3'd3,
        MD_VERIFY  = 3'd4,
        MD_PROG    = 3'd5,
        MD_ERASE   = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_MFR   = 2'd1,
        SRC_DEV   = 2'd2
    } rdsrc_e;

    typedef enum logic {
        UL_IDLE  = 1'b0,
        UL_ARMED = 1'b1
    } unlock_e;

    // Sampled control pins
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic vpp_hi;
        logic a9_hv;
        logic a0;
    } ctl_t;

    // Decoded view of the device
    typedef struct packed {
        mode_e  mode;
        rdsrc_e src;
        logic   drive;
        logic   idle;
    } view_t;

    localparam logic [7:0]  MFR_CODE = 8'hDA;
    localparam logic [7:0]  DEV_CODE = 8'h85;
    localparam logic [15:0] UNLK_ADDR1 = 16'h5555;
    localparam logic [7:0]  UNLK_DATA1 = 8'hAA;
    localparam logic [15:0] UNLK_ADDR2 = 16'h2AAA;
    localparam logic [7:0]  UNLK_DATA2 = 8'h10;

    function automatic logic [7:0] id_code(rdsrc_e s);
        case (s)
            SRC_MFR: id_code = MFR_CODE;
            SRC_DEV: id_code = DEV_CODE;
            default: id_code = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_ctl_pkg::*;
(
    input  ctl_t  pins,
    output view_t view
);
    always_comb begin
        view.mode  = MD_OUT_DIS;
        view.src   = SRC_ARRAY;
        view.drive = 1'b0;
        view.idle  = 1'b0;
        if (pins.ce_n) begin
            view.mode = MD_STANDBY;
            view.idle = 1'b1;
        end else if (!pins.oe_n) begin
            view.drive = 1'b1;
            if (pins.a9_hv && !pins.vpp_hi) begin
                view.mode = MD_ID_READ;
                view.src  = pins.a0 ? SRC_DEV : SRC_MFR;
            end else if (pins.vpp_hi) begin
                view.mode = MD_VERIFY;
            end else begin
                view.mode = MD_READ;
            end
        end else if (pins.vpp_hi && !pins.pgm_n) begin
            view.mode = (pins.a9_hv && !pins.a0) ? MD_ERASE : MD_PROG;
        end
    end
endmodule

// File: rtl/eprom_strobe_meter.sv
module eprom_strobe_meter #(
    parameter int PW_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pgm_n,
    output logic            rise,
    output logic [PW_W-1:0] low_cnt
);
    localparam logic [PW_W-1:0] CNT_MAX = {PW_W{1'b1}};

    logic pgm_q;

    assign rise = !pgm_q && pgm_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pgm_q   <= 1'b1;
            low_cnt <= '0;
        end else begin
            pgm_q <= pgm_n;
            if (!pgm_n) begin
                if (pgm_q)
                    low_cnt <= PW_W'(1);
                else if (low_cnt != CNT_MAX)
                    low_cnt <= low_cnt + PW_W'(1);
            end
        end
    end
endmodule

// File: rtl/eprom_unlock_seq.sv
module eprom_unlock_seq
    import eprom_ctl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              hv_erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              do_prog,
    output logic              do_erase
);
    unlock_e st, st_nxt;
    logic    hit_first, hit_second;

    assign hit_first  = (addr == ADDR_W'(UNLK_ADDR1)) && (data == DATA_W'(UNLK_DATA1));
    assign hit_second = (addr == ADDR_W'(UNLK_ADDR2)) && (data == DATA_W'(UNLK_DATA2));

    always_comb begin
        st_nxt   = st;
        do_prog  = 1'b0;
        do_erase = 1'b0;
        if (wr) begin
            if (hv_erase) begin
                do_erase = 1'b1;
                st_nxt   = UL_IDLE;
            end else if (st == UL_ARMED && hit_second) begin
                do_erase = 1'b1;
                st_nxt   = UL_IDLE;
            end else if (hit_first) begin
                st_nxt   = UL_ARMED;
            end else begin
                do_prog  = 1'b1;
                st_nxt   = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= UL_IDLE;
        else     st <= st_nxt;
    end
endmodule

// File: rtl/eprom_mode_ctl.sv
module eprom_mode_ctl
    import eprom_ctl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int PW_W   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              bus_oe,
    output logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] id_byte,
    output logic [2:0]        mode,
    output logic              standby,
    output logic              prog_stb,
    output logic              erase_stb,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [PW_W-1:0]   pulse_cycles
);
    ctl_t            pins;
    view_t           view;
    logic            rise, wr, hv_erase, do_prog, do_erase;
    logic [PW_W-1:0] low_cnt;

    always_comb begin
        pins.ce_n   = ce_n;
        pins.oe_n   = oe_n;
        pins.pgm_n  = pgm_n;
        pins.vpp_hi = vpp_hi;
        pins.a9_hv  = a9_hv;
        pins.a0     = addr[0];
    end

    eprom_mode_decode u_dec (.pins(pins), .view(view));

    eprom_strobe_meter #(.PW_W(PW_W)) u_meter (
        .clk(clk), .rst(rst), .pgm_n(pgm_n), .rise(rise), .low_cnt(low_cnt)
    );

    assign wr       = rise && !ce_n && oe_n && vpp_hi;
    assign hv_erase = a9_hv && !addr[0];

    eprom_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
        .clk(clk), .rst(rst), .wr(wr), .hv_erase(hv_erase),
        .addr(addr), .data(din), .do_prog(do_prog), .do_erase(do_erase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_oe       <= 1'b0;
            rd_sel       <= SRC_ARRAY;
            id_byte      <= '0;
            mode         <= MD_STANDBY;
            standby      <= 1'b1;
            prog_stb     <= 1'b0;
            erase_stb    <= 1'b0;
            op_addr      <= '0;
            op_data      <= '0;
            pulse_cycles <= '0;
        end else begin
            bus_oe    <= view.drive;
            rd_sel    <= view.src;
            id_byte   <= DATA_W'(id_code(view.src));
            mode      <= view.mode;
            standby   <= view.idle;
            prog_stb  <= do_prog;
            erase_stb <= do_erase;
            if (wr) begin
                op_addr      <= addr;
                op_data      <= din;
                pulse_cycles <= low_cnt;
            end
        end
    end
endmodule

// File: rtl/eprom_mode_ctl_chk.sv
module eprom_mode_ctl_chk #(
    parameter int PW_W = 20
) (
    input logic            clk,
    input logic            rst,
    input logic            ce_n,
    input logic            oe_n,
    input logic            pgm_n,
    input logic            vpp_hi,
    input logic            bus_oe,
    input logic [1:0]      rd_sel,
    input logic [2:0]      mode,
    input logic            standby,
    input logic            prog_stb,
    input logic            erase_stb,
    input logic [PW_W-1:0] pulse_cycles
);
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (standby && !bus_oe && mode == 3'd0));

    a_r2_drive_needs_enables: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> $past(!ce_n && !oe_n));

    a_r3_id_source_in_id_mode: assert property (@(posedge clk) disable iff (rst)
        (rd_sel != 2'd0) |-> (mode == 3'd3));

    a_r5_pulse_measured: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb) |-> (pulse_cycles != '0));

    a_r6_write_qualified: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb) |-> $past(!ce_n && oe_n && vpp_hi && pgm_n));

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(prog_stb && erase_stb));

    a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb) |=> !(prog_stb || erase_stb));
endmodule

bind eprom_mode_ctl eprom_mode_ctl_chk #(.PW_W(PW_W)) u_chk (.*);

// File: tb/tb_eprom_mode_ctl.sv
module tb_eprom_mode_ctl;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int PW_W   = 20;

    logic              clk = 1'b0;
    logic              rst, ce_n, oe_n, pgm_n, vpp_hi, a9_hv;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] din;
    logic              bus_oe, standby, prog_stb, erase_stb;
    logic [1:0]        rd_sel;
    logic [DATA_W-1:0] id_byte, op_data;
    logic [2:0]        mode;
    logic [ADDR_W-1:0] op_addr;
    logic [PW_W-1:0]   pulse_cycles;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    eprom_mode_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW_W(PW_W)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
        .bus_oe(bus_oe), .rd_sel(rd_sel), .id_byte(id_byte), .mode(mode),
        .standby(standby), .prog_stb(prog_stb), .erase_stb(erase_stb),
        .op_addr(op_addr), .op_data(op_data), .pulse_cycles(pulse_cycles)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_pins();
        ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hv = 0; addr = '0; din = '0;
    endtask

    // Strobe of n low cycles; returns one step after release
    task automatic write_pulse(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                               input int n, input logic ce, input logic oe,
                               input logic vpp, input logic a9,
                               input logic [2:0] exp_mode, input string req);
        ce_n = ce; oe_n = oe; vpp_hi = vpp; a9_hv = a9; addr = a; din = d; pgm_n = 1;
        step();
        pgm_n = 0;
        repeat (n) step();
        check(req, "mode while strobe low", 32'(mode), 32'(exp_mode));
        pgm_n = 1;
        step();
    endtask

    task automatic expect_strobes(input string req, input logic p, input logic e);
        check(req, "prog_stb", 32'(prog_stb), 32'(p));
        check(req, "erase_stb", 32'(erase_stb), 32'(e));
    endtask

    task automatic t_reset();
        check("R1", "reset standby", 32'(standby), 1);
        check("R1", "reset bus_oe", 32'(bus_oe), 0);
        check("R1", "reset mode", 32'(mode), 0);
        expect_strobes("R1", 0, 0);
    endtask

    task automatic t_standby();
        ce_n = 1; oe_n = 0; pgm_n = 0; vpp_hi = 1;
        step();
        check("R1", "standby with oe/pgm low", 32'(standby), 1);
        check("R1", "bus_oe deselected", 32'(bus_oe), 0);
        check("R1", "mode deselected", 32'(mode), 0);
        pgm_n = 1;
        step();
        expect_strobes("R6", 0, 0);
        idle_pins();
        step();
    endtask

    task automatic t_read();
        ce_n = 0; oe_n = 0; vpp_hi = 0; a9_hv = 0; addr = 18'h00123;
        step();
        check("R2", "read mode", 32'(mode), 2);
        check("R2", "read bus_oe", 32'(bus_oe), 1);
        check("R2", "read rd_sel", 32'(rd_sel), 0);
        check("R2", "read standby", 32'(standby), 0);
        oe_n = 1;
        step();
        check("R2", "out-disable mode", 32'(mode), 1);
        check("R2", "out-disable bus_oe", 32'(bus_oe), 0);
        idle_pins();
        step();
    endtask

    task automatic t_id();
        ce_n = 0; oe_n = 0; vpp_hi = 0; a9_hv = 1; addr = 18'h00000;
        step();
        check("R3", "id mode", 32'(mode), 3);
        check("R3", "maker select", 32'(rd_sel), 1);
        check("R3", "maker code", 32'(id_byte), 32'h DA);
        addr = 18'h00001;
        step();
        check("R3", "device select", 32'(rd_sel), 2);
        check("R3", "device code", 32'(id_byte), 32'h85);
        check("R3", "id bus_oe", 32'(bus_oe), 1);
        idle_pins();
        step();
    endtask

    task automatic t_verify();
        ce_n = 0; oe_n = 0; vpp_hi = 1; a9_hv = 0; addr = 18'h0ABCD;
        step();
        check("R4", "verify mode", 32'(mode), 4);
        check("R4", "verify bus_oe", 32'(bus_oe), 1);
        check("R4", "verify rd_sel", 32'(rd_sel), 0);
        idle_pins();
        step();
    endtask

    task automatic t_program();
        write_pulse(18'h12345, 8'h3C, 5, 0, 1, 1, 0, 3'd5, "R5");
        expect_strobes("R5", 1, 0);
        check("R5", "op_addr", 32'(op_addr), 32'h12345);
        check("R5", "op_data", 32'(op_data), 32'h3C);
        check("R5", "pulse_cycles", 32'(pulse_cycles), 5);
        step();
        expect_strobes("R11", 0, 0);
        write_pulse(18'h3FFFF, 8'h00, 1, 0, 1, 1, 0, 3'd5, "R5");
        expect_strobes("R5", 1, 0);
        check("R5", "short pulse_cycles", 32'(pulse_cycles), 1);
        check("R5", "op_addr top", 32'(op_addr), 32'h3FFFF);
        idle_pins();
        step();
    endtask

    task automatic t_inhibit();
        write_pulse(18'h00010, 8'h11, 3, 1, 1, 1, 0, 3'd0, "R6");
        expect_strobes("R6", 0, 0);
        write_pulse(18'h00020, 8'h22, 3, 0, 0, 1, 0, 3'd4, "R6");
        expect_strobes("R6", 0, 0);
        write_pulse(18'h00030, 8'h33, 3, 0, 1, 0, 0, 3'd1, "R6");
        expect_strobes("R6", 0, 0);
        idle_pins();
        step();
    endtask

    task automatic t_hv_erase();
        write_pulse(18'h00100, 8'hFF, 7, 0, 1, 1, 1, 3'd6, "R7");
        expect_strobes("R7", 0, 1);
        check("R7", "erase pulse_cycles", 32'(pulse_cycles), 7);
        write_pulse(18'h00101, 8'h5A, 4, 0, 1, 1, 1, 3'd5, "R7");
        expect_strobes("R7", 1, 0);
        check("R7", "a0 high op_data", 32'(op_data), 32'h5A);
        idle_pins();
        step();
    endtask

    task automatic t_unlock();
        write_pulse(18'h05555, 8'hAA, 2, 0, 1, 1, 0, 3'd5, "R8");
        expect_strobes("R8", 0, 0);
        write_pulse(18'h02AAA, 8'h10, 9, 0, 1, 1, 0, 3'd5, "R9");
        expect_strobes("R9", 0, 1);
        check("R9", "unlock pulse_cycles", 32'(pulse_cycles), 9);
        step();
        expect_strobes("R11", 0, 0);
        // Upper address bit set: not the command address
        write_pulse(18'h15555, 8'hAA, 2, 0, 1, 1, 0, 3'd5, "R8");
        expect_strobes("R8", 1, 0);
        idle_pins();
        step();
    endtask

    task automatic t_break();
        write_pulse(18'h05555, 8'hAA, 2, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 0, 0);
        write_pulse(18'h00777, 8'h5A, 3, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 1, 0);
        check("R10", "breaking op_addr", 32'(op_addr), 32'h777);
        write_pulse(18'h02AAA, 8'h10, 4, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 1, 0);
        // repeated first command stays armed
        write_pulse(18'h05555, 8'hAA, 2, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 0, 0);
        write_pulse(18'h05555, 8'hAA, 2, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 0, 0);
        write_pulse(18'h02AAA, 8'h10, 6, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 0, 1);
        // wrong data on the second command
        write_pulse(18'h05555, 8'hAA, 2, 0, 1, 1, 0, 3'd5, "R10");
        write_pulse(18'h02AAA, 8'h11, 2, 0, 1, 1, 0, 3'd5, "R10");
        expect_strobes("R10", 1, 0);
        idle_pins();
        step();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_pins();
        rst = 1;
        repeat (3) step();
        rst = 0;
        t_reset();
        t_standby();
        t_read();
        t_id();
        t_verify();
        t_program();
        t_inhibit();
        t_hv_erase();
        t_unlock();
        t_break();
        repeat (2) step();
        finish_run();
    end
endmodule